// File: doc/BRIEF.md
# Processor exception entry controller

This block is the entry side of exception handling in the system-control coprocessor of a 32-bit RISC core. The pipeline reports a synchronous fault with a one-cycle request that carries the fault kind, the faulting address, a vector for translation faults and a coprocessor number. The block also watches seven direct interrupt lines and a masked external summary. From these it maintains the Status, Cause, EPC, BadVAddr, Context and EntryHi registers and tells the fetch stage where to go next, using a one-cycle redirect strobe and a target PC.

A synchronous fault is not taken in the cycle it is reported. Its vector, PC and delay-slot flag go into a single pending slot, and the cycle after that the entry takes place from the latched values and the slot empties. Interrupts are evaluated in every idle cycle and are taken at once when Status allows them. A small write port lets software load Status and Cause.

The sequencer has two states. SEQ_IDLE moves to SEQ_PEND on a fault request (transition *capture*). Otherwise it stays in SEQ_IDLE and may take an interrupt. SEQ_PEND always returns to SEQ_IDLE on the next edge (transition *take*). A request that arrives in SEQ_PEND is refused.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, Status, Cause (apart from the live IP field), EPC, BadVAddr, Context and EntryHi are zero, and both redirect and overlap are low.
- R2: A fault request in an idle cycle is captured at that edge and taken one edge later. The take raises redirect for exactly one cycle with the general vector 0x80000180 for break (kind 0), syscall (kind 1) and coprocessor unusable (kind 2). It sets Status EXL (bit 1) and loads EPC from the PC latched at the request, not from the current PC.
- R3: If the delay-slot flag was set for the entry, EPC is that PC minus 4 and Cause BD (bit 31) is 1. Otherwise EPC is the PC and BD is 0.
- R4: At capture, the Cause code field (bits 6:2) gets 9 for break, 8 for syscall, 11 for coprocessor unusable, 2 for TLB load (kind 3) and 3 for TLB store (kind 4). All other stored Cause bits keep their values.
- R5: A coprocessor-unusable fault writes the request's coprocessor number into Cause CE (bits 29:28). Other kinds leave CE unchanged.
- R6: A TLB fault loads BadVAddr with the address. Context bits 22:4 get address bits 31:13 and bits 3:0 become zero, with bits 31:23 kept. EntryHi bits 31:13 get address bits 31:13, with bits 12:0 kept. The redirect target is the vector given with the request.
- R7: A fault request while the slot is occupied raises overlap in that same cycle and is dropped. The occupying fault completes unchanged.
- R8: An interrupt is taken only when Status IE (bit 0) is 1, EXL (bit 1) and ERL (bit 2) are 0, and Status IM (bits 15:8) ANDed with Cause IP is nonzero.
- R9: A taken interrupt redirects on the next edge to 0x80000180. It sets code 0 and EXL, and forms EPC and BD from the current PC and delay flag as in R3.
- R10: Cause IP bit 3 (Cause bit 11) always equals the OR of the external pending bits ANDed with their mask. IP bits 0–2 follow interrupt lines 0–2, and IP bits 4–7 follow lines 3–6.
- R11: A fault request or an occupied slot blocks the interrupt in that cycle, so the fault's vector and code win.
- R12: A Status write loads all 32 bits. A Cause write loads every bit except the IP field, which stays live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | PC of the instruction at the head of the pipeline |
| in_delay_slot | input | 1 | That instruction sits in a branch delay slot |
| exc_req | input | 1 | One-cycle synchronous fault request |
| exc_kind | input | 3 | Fault kind (0 break, 1 syscall, 2 cop unusable, 3 TLB load, 4 TLB store) |
| exc_cop | input | 2 | Coprocessor number for kind 2 |
| exc_vaddr | input | 32 | Faulting virtual address for TLB kinds |
| exc_vector | input | 32 | Target vector for TLB kinds |
| irq_hw | input | 7 | Direct interrupt lines for IP 0–2 and 4–7 |
| ext_pend | input | EXT_W | External interrupt pending bits |
| ext_mask | input | EXT_W | External interrupt mask bits |
| csr_wr_status | input | 1 | Write csr_wdata to Status |
| csr_wr_cause | input | 1 | Write csr_wdata to Cause (IP excluded) |
| csr_wdata | input | 32 | Write data |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register with live IP field |
| epc_o | output | 32 | Exception PC |
| badvaddr_o | output | 32 | Faulting address register |
| context_o | output | 32 | Context register |
| entryhi_o | output | 32 | EntryHi register |
| redirect_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | 32 | Redirect target |
| overlap_o | output | 1 | Fault request refused because the slot is occupied |

## Verification
A sequencer stuck in SEQ_PEND shows up on the cycle after any entry in one of two ways: a repeated redirect strobe, or an overlap flag on the next request. A slot that has lost its contents shows at the very redirect, as a wrong EPC or target while cur_pc has already moved on. A Cause field corrupted at capture is visible one edge after the request, before the redirect. A wrong interrupt gate shows as a redirect, or a missing one, one edge after the pending line changes. The directed cases set the PC apart for capture and for take so that each of these shows up at the ports.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN      = 32;
    localparam int ST_IE     = 0;
    localparam int ST_EXL    = 1;
    localparam int ST_ERL    = 2;
    localparam int FLD_LO    = 8;   // Status IM and Cause IP share this span
    localparam int FLD_W     = 8;
    localparam int CODE_LO   = 2;
    localparam int CODE_W    = 5;
    localparam int CE_LO     = 28;
    localparam int BD_BIT    = 31;
    localparam int VPN_LO    = 13;
    localparam int CTX_KEEP  = 23;
    localparam int SUM_LINE  = 3;   // IP position driven by the external summary

    typedef enum logic [2:0] {
        EK_BREAK   = 3'd0,
        EK_SYSCALL = 3'd1,
        EK_COPUN   = 3'd2,
        EK_TLBL    = 3'd3,
        EK_TLBS    = 3'd4
    } exc_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_PEND = 1'b1
    } seq_state_e;

    function automatic logic [CODE_W-1:0] kind_code(input logic [2:0] k);
        logic [CODE_W-1:0] c;
        unique case (k)
            3'(EK_SYSCALL): c = 5'd8;
            3'(EK_COPUN):   c = 5'd11;
            3'(EK_TLBL):    c = 5'd2;
            3'(EK_TLBS):    c = 5'd3;
            default:        c = 5'd9;
        endcase
        return c;
    endfunction

    function automatic logic is_tlb(input logic [2:0] k);
        return (k == 3'(EK_TLBL)) || (k == 3'(EK_TLBS));
    endfunction
endpackage

// File: rtl/exc_irq_eval.sv
module exc_irq_eval
    import exc_entry_pkg::*;
#(
    parameter int EXT_W = 8
) (
    input  logic [FLD_W-2:0] irq_hw,
    input  logic [EXT_W-1:0] ext_pend,
    input  logic [EXT_W-1:0] ext_mask,
    input  logic             st_ie,
    input  logic             st_exl,
    input  logic             st_erl,
    input  logic [FLD_W-1:0] st_im,
    output logic [FLD_W-1:0] ip_vec,
    output logic             irq_ok
);
    logic ext_sum;
    assign ext_sum = |(ext_pend & ext_mask);

    for (genvar i = 0; i < FLD_W; i++) begin : g_ip
        if (i == SUM_LINE) begin : g_sum
            assign ip_vec[i] = ext_sum;
        end else if (i < SUM_LINE) begin : g_low
            assign ip_vec[i] = irq_hw[i];
        end else begin : g_high
            assign ip_vec[i] = irq_hw[i-1];
        end
    end

    assign irq_ok = st_ie && !st_exl && !st_erl && |(st_im & ip_vec);
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] GEN_VEC = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_req,
    input  logic [2:0]      exc_kind,
    input  logic [XLEN-1:0] exc_vector,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            in_delay_slot,
    input  logic            irq_ok,
    output logic            latch_en,
    output logic            take_sync,
    output logic            take_irq,
    output logic            overlap,
    output logic [XLEN-1:0] slot_pc,
    output logic            slot_dly,
    output logic [XLEN-1:0] slot_vec
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (exc_req) state_d = SEQ_PEND;   // capture
            SEQ_PEND: state_d = SEQ_IDLE;                // take
        endcase
    end

    always_comb begin
        latch_en  = 1'b0;
        take_sync = 1'b0;
        take_irq  = 1'b0;
        overlap   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                latch_en = exc_req;
                take_irq = !exc_req && irq_ok;
            end
            SEQ_PEND: begin
                take_sync = 1'b1;
                overlap   = exc_req;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_pc  <= '0;
            slot_dly <= 1'b0;
            slot_vec <= '0;
        end else if (latch_en) begin
            slot_pc  <= cur_pc;
            slot_dly <= in_delay_slot;
            slot_vec <= is_tlb(exc_kind) ? exc_vector : GEN_VEC;
        end
    end

    // R2
    slot_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> take_sync);
    // R7
    overlap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap |=> !take_sync);
endmodule

// File: rtl/exc_cp0_state.sv
module exc_cp0_state
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] GEN_VEC = 32'h8000_0180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_en,
    input  logic             take_sync,
    input  logic             take_irq,
    input  logic [2:0]       exc_kind,
    input  logic [1:0]       exc_cop,
    input  logic [XLEN-1:0]  exc_vaddr,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             in_delay_slot,
    input  logic [XLEN-1:0]  slot_pc,
    input  logic             slot_dly,
    input  logic [XLEN-1:0]  slot_vec,
    input  logic [FLD_W-1:0] ip_vec,
    input  logic             wr_status,
    input  logic             wr_cause,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  status_q,
    output logic [XLEN-1:0]  cause_q,
    output logic [XLEN-1:0]  epc_q,
    output logic [XLEN-1:0]  badv_q,
    output logic [XLEN-1:0]  ctx_q,
    output logic [XLEN-1:0]  ehi_q,
    output logic             redir_q,
    output logic [XLEN-1:0]  redir_pc_q
);
    logic [XLEN-1:0] status_d, cause_r, cause_d, epc_d, badv_d, ctx_d, ehi_d, redir_pc_d;
    logic            redir_d;
    logic [XLEN-1:0] entry_pc;
    logic            entry_dly;

    assign entry_pc  = take_sync ? slot_pc  : cur_pc;
    assign entry_dly = take_sync ? slot_dly : in_delay_slot;

    always_comb begin
        status_d   = status_q;
        cause_d    = cause_r;
        epc_d      = epc_q;
        badv_d     = badv_q;
        ctx_d      = ctx_q;
        ehi_d      = ehi_q;
        redir_d    = 1'b0;
        redir_pc_d = redir_pc_q;
        if (wr_status) status_d = wdata;
        if (wr_cause)  cause_d  = wdata;
        if (latch_en) begin
            cause_d[CODE_LO +: CODE_W] = kind_code(exc_kind);
            if (exc_kind == 3'(EK_COPUN)) cause_d[CE_LO +: 2] = exc_cop;
            if (is_tlb(exc_kind)) begin
                badv_d = exc_vaddr;
                ctx_d  = {ctx_q[XLEN-1:CTX_KEEP], exc_vaddr[XLEN-1:VPN_LO], 4'b0000};
                ehi_d  = {exc_vaddr[XLEN-1:VPN_LO], ehi_q[VPN_LO-1:0]};
            end
        end
        if (take_sync || take_irq) begin
            status_d[ST_EXL] = 1'b1;
            epc_d            = entry_dly ? entry_pc - 32'd4 : entry_pc;
            cause_d[BD_BIT]  = entry_dly;
            redir_d          = 1'b1;
            redir_pc_d       = take_sync ? slot_vec : GEN_VEC;
            if (take_irq) cause_d[CODE_LO +: CODE_W] = '0;
        end
        cause_d[FLD_LO +: FLD_W] = '0;  // IP is never stored
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q   <= '0;
            cause_r    <= '0;
            epc_q      <= '0;
            badv_q     <= '0;
            ctx_q      <= '0;
            ehi_q      <= '0;
            redir_q    <= 1'b0;
            redir_pc_q <= '0;
        end else begin
            status_q   <= status_d;
            cause_r    <= cause_d;
            epc_q      <= epc_d;
            badv_q     <= badv_d;
            ctx_q      <= ctx_d;
            ehi_q      <= ehi_d;
            redir_q    <= redir_d;
            redir_pc_q <= redir_pc_d;
        end
    end

    assign cause_q = cause_r | {{(XLEN-FLD_LO-FLD_W){1'b0}}, ip_vec, {FLD_LO{1'b0}}};

    // R2
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_q |=> !redir_q);
    // R2
    exl_on_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_q |-> status_q[ST_EXL]);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int               EXT_W   = 8,
    parameter logic [XLEN-1:0]  GEN_VEC = 32'h8000_0180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cur_pc,
    input  logic             in_delay_slot,
    input  logic             exc_req,
    input  logic [2:0]       exc_kind,
    input  logic [1:0]       exc_cop,
    input  logic [31:0]      exc_vaddr,
    input  logic [31:0]      exc_vector,
    input  logic [6:0]       irq_hw,
    input  logic [EXT_W-1:0] ext_pend,
    input  logic [EXT_W-1:0] ext_mask,
    input  logic             csr_wr_status,
    input  logic             csr_wr_cause,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      status_o,
    output logic [31:0]      cause_o,
    output logic [31:0]      epc_o,
    output logic [31:0]      badvaddr_o,
    output logic [31:0]      context_o,
    output logic [31:0]      entryhi_o,
    output logic             redirect_o,
    output logic [31:0]      redirect_pc_o,
    output logic             overlap_o
);
    logic [FLD_W-1:0] ip_vec;
    logic             irq_ok, latch_en, take_sync, take_irq, slot_dly;
    logic [XLEN-1:0]  slot_pc, slot_vec;

    exc_irq_eval #(.EXT_W(EXT_W)) u_irq (
        .irq_hw   (irq_hw),
        .ext_pend (ext_pend),
        .ext_mask (ext_mask),
        .st_ie    (status_o[ST_IE]),
        .st_exl   (status_o[ST_EXL]),
        .st_erl   (status_o[ST_ERL]),
        .st_im    (status_o[FLD_LO +: FLD_W]),
        .ip_vec   (ip_vec),
        .irq_ok   (irq_ok)
    );

    exc_sequencer #(.GEN_VEC(GEN_VEC)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_req       (exc_req),
        .exc_kind      (exc_kind),
        .exc_vector    (exc_vector),
        .cur_pc        (cur_pc),
        .in_delay_slot (in_delay_slot),
        .irq_ok        (irq_ok),
        .latch_en      (latch_en),
        .take_sync     (take_sync),
        .take_irq      (take_irq),
        .overlap       (overlap_o),
        .slot_pc       (slot_pc),
        .slot_dly      (slot_dly),
        .slot_vec      (slot_vec)
    );

    exc_cp0_state #(.GEN_VEC(GEN_VEC)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .latch_en      (latch_en),
        .take_sync     (take_sync),
        .take_irq      (take_irq),
        .exc_kind      (exc_kind),
        .exc_cop       (exc_cop),
        .exc_vaddr     (exc_vaddr),
        .cur_pc        (cur_pc),
        .in_delay_slot (in_delay_slot),
        .slot_pc       (slot_pc),
        .slot_dly      (slot_dly),
        .slot_vec      (slot_vec),
        .ip_vec        (ip_vec),
        .wr_status     (csr_wr_status),
        .wr_cause      (csr_wr_cause),
        .wdata         (csr_wdata),
        .status_q      (status_o),
        .cause_q       (cause_o),
        .epc_q         (epc_o),
        .badv_q        (badvaddr_o),
        .ctx_q         (context_o),
        .ehi_q         (entryhi_o),
        .redir_q       (redirect_o),
        .redir_pc_q    (redirect_pc_o)
    );

    // R10
    ip3_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o[FLD_LO + SUM_LINE] == |(ext_pend & ext_mask));
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> status_o[ST_IE] && !status_o[ST_EXL] && !status_o[ST_ERL]);
    // R11
    fault_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || take_sync) |-> !take_irq);
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GEN = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        in_delay_slot = 1'b0;
    logic        exc_req = 1'b0;
    logic [2:0]  exc_kind = '0;
    logic [1:0]  exc_cop = '0;
    logic [31:0] exc_vaddr = '0;
    logic [31:0] exc_vector = '0;
    logic [6:0]  irq_hw = '0;
    logic [7:0]  ext_pend = '0;
    logic [7:0]  ext_mask = '0;
    logic        csr_wr_status = 1'b0;
    logic        csr_wr_cause = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] status_o, cause_o, epc_o, badvaddr_o, context_o, entryhi_o, redirect_pc_o;
    logic        redirect_o, overlap_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .in_delay_slot(in_delay_slot),
        .exc_req(exc_req), .exc_kind(exc_kind), .exc_cop(exc_cop), .exc_vaddr(exc_vaddr),
        .exc_vector(exc_vector), .irq_hw(irq_hw), .ext_pend(ext_pend), .ext_mask(ext_mask),
        .csr_wr_status(csr_wr_status), .csr_wr_cause(csr_wr_cause), .csr_wdata(csr_wdata),
        .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o), .badvaddr_o(badvaddr_o),
        .context_o(context_o), .entryhi_o(entryhi_o), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o), .overlap_o(overlap_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic csr_write(input bit cause_sel, input logic [31:0] d);
        @(negedge clk);
        csr_wr_status = !cause_sel;
        csr_wr_cause  = cause_sel;
        csr_wdata     = d;
        @(negedge clk);
        csr_wr_status = 1'b0;
        csr_wr_cause  = 1'b0;
    endtask

    function automatic logic [31:0] code_of(input logic [31:0] c);
        return {27'b0, c[6:2]};
    endfunction

    // Full fault flow: request, capture check, take check, strobe end
    task automatic sync_fault(input logic [2:0] kind, input logic [31:0] pc, input bit dly,
                              input logic [1:0] cop, input logic [31:0] va,
                              input logic [31:0] vec, input logic [4:0] exp_code,
                              input logic [31:0] exp_vec);
        @(negedge clk);
        exc_req = 1'b1; exc_kind = kind; exc_cop = cop; exc_vaddr = va;
        exc_vector = vec; cur_pc = pc; in_delay_slot = dly;
        @(negedge clk);
        exc_req = 1'b0; cur_pc = pc + 32'h100; in_delay_slot = 1'b0;
        check("R2 no redirect at capture", {31'b0, redirect_o}, 32'd0);
        check("R4 code at capture", code_of(cause_o), {27'b0, exp_code});
        @(negedge clk);
        check("R2 redirect strobe", {31'b0, redirect_o}, 32'd1);
        check("R2/R6 redirect target", redirect_pc_o, exp_vec);
        check("R2 EXL set", {31'b0, status_o[1]}, 32'd1);
        check("R3 EPC", epc_o, dly ? pc - 32'd4 : pc);
        check("R3 BD", {31'b0, cause_o[31]}, {31'b0, dly});
        @(negedge clk);
        check("R2 strobe one cycle", {31'b0, redirect_o}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 status", status_o, 32'd0);
        check("R1 cause", cause_o, 32'd0);
        check("R1 epc", epc_o, 32'd0);
        check("R1 badvaddr", badvaddr_o, 32'd0);
        check("R1 context", context_o, 32'd0);
        check("R1 entryhi", entryhi_o, 32'd0);
        check("R1 redirect", {31'b0, redirect_o}, 32'd0);
        check("R1 overlap", {31'b0, overlap_o}, 32'd0);
    endtask

    task automatic t_break_syscall;
        sync_fault(3'd0, 32'h0000_1000, 1'b0, 2'd0, '0, '0, 5'd9, GEN);
        csr_write(1'b0, 32'h0);
        sync_fault(3'd1, 32'h0000_2004, 1'b1, 2'd0, '0, '0, 5'd8, GEN);
        csr_write(1'b0, 32'h0);
    endtask

    task automatic t_cause_preserve;
        csr_write(1'b1, 32'hFFFF_FFFF);
        check("R12 cause write keeps IP live", cause_o, 32'hFFFF_00FF);
        csr_write(1'b0, 32'h1234_0000);
        check("R12 status write", status_o, 32'h1234_0000);
        csr_write(1'b0, 32'h0);
        sync_fault(3'd0, 32'h0000_3000, 1'b0, 2'd0, '0, '0, 5'd9, GEN);
        check("R4/R5 other cause bits kept", cause_o, 32'h7FFF_00A7);
        csr_write(1'b0, 32'h0);
    endtask

    task automatic t_cop;
        sync_fault(3'd2, 32'h0000_4000, 1'b0, 2'd1, '0, '0, 5'd11, GEN);
        check("R5 CE field", {30'b0, cause_o[29:28]}, 32'd1);
        csr_write(1'b0, 32'h0);
    endtask

    task automatic t_tlb;
        logic [31:0] va = 32'h1234_5678;
        sync_fault(3'd3, 32'h0000_5000, 1'b0, 2'd0, va, 32'h8000_0000, 5'd2, 32'h8000_0000);
        check("R6 badvaddr", badvaddr_o, va);
        check("R6 context", context_o, (va >> 13) << 4);
        check("R6 entryhi", entryhi_o, va & 32'hFFFF_E000);
        csr_write(1'b0, 32'h0);
    endtask

    task automatic t_overlap;
        @(negedge clk);
        exc_req = 1'b1; exc_kind = 3'd0; cur_pc = 32'h0000_6000; in_delay_slot = 1'b0;
        #1 check("R7 no overlap when idle", {31'b0, overlap_o}, 32'd0);
        @(negedge clk);
        exc_kind = 3'd1; cur_pc = 32'h0000_7000;
        check("R7 overlap raised", {31'b0, overlap_o}, 32'd1);
        @(negedge clk);
        exc_req = 1'b0;
        check("R7 first fault taken", {31'b0, redirect_o}, 32'd1);
        check("R7 first fault EPC", epc_o, 32'h0000_6000);
        check("R7 dropped fault left code", code_of(cause_o), 32'd9);
        @(negedge clk);
        check("R7 no second entry", {31'b0, redirect_o}, 32'd0);
        csr_write(1'b0, 32'h0);
    endtask

    task automatic irq_blocked(input string req, input logic [31:0] st, input logic [6:0] hw,
                               input logic [7:0] pend, input logic [7:0] msk);
        csr_write(1'b0, st);
        @(negedge clk);
        irq_hw = hw; ext_pend = pend; ext_mask = msk;
        @(negedge clk);
        check(req, {31'b0, redirect_o}, 32'd0);
        @(negedge clk);
        check(req, {31'b0, redirect_o}, 32'd0);
        irq_hw = '0; ext_pend = '0; ext_mask = '0;
    endtask

    task automatic t_irq;
        // IP5 is line 4, IM bit 13
        irq_blocked("R8 IE clear", 32'h0000_2000, 7'b001_0000, 8'h0, 8'h0);
        irq_blocked("R8 EXL set", 32'h0000_2003, 7'b001_0000, 8'h0, 8'h0);
        irq_blocked("R8 ERL set", 32'h0000_2005, 7'b001_0000, 8'h0, 8'h0);
        irq_blocked("R8 mask mismatch", 32'h0000_0401, 7'b001_0000, 8'h0, 8'h0);
        irq_blocked("R10 external masked off", 32'h0000_0801, 7'b000_0000, 8'h10, 8'h00);
        csr_write(1'b0, 32'h0000_2001);
        @(negedge clk);
        irq_hw = 7'b001_0000; cur_pc = 32'h0000_8008; in_delay_slot = 1'b1;
        @(negedge clk);
        check("R9 interrupt redirect", {31'b0, redirect_o}, 32'd1);
        check("R9 general vector", redirect_pc_o, GEN);
        check("R9 code zero", code_of(cause_o), 32'd0);
        check("R9 EPC rewound", epc_o, 32'h0000_8004);
        check("R9 BD", {31'b0, cause_o[31]}, 32'd1);
        check("R10 IP5 from line 4", {31'b0, cause_o[13]}, 32'd1);
        irq_hw = '0; in_delay_slot = 1'b0;
        @(negedge clk);
        check("R9 single strobe", {31'b0, redirect_o}, 32'd0);
        csr_write(1'b0, 32'h0000_0801);
        @(negedge clk);
        ext_pend = 8'h10; ext_mask = 8'h10; cur_pc = 32'h0000_9000;
        #1 check("R10 IP3 summary", {31'b0, cause_o[11]}, 32'd1);
        @(negedge clk);
        check("R10 summary interrupt taken", {31'b0, redirect_o}, 32'd1);
        check("R9 EPC plain", epc_o, 32'h0000_9000);
        ext_pend = '0; ext_mask = '0;
        #1 check("R10 IP3 cleared", {31'b0, cause_o[11]}, 32'd0);
        csr_write(1'b0, 32'h0);
    endtask

    task automatic t_priority;
        csr_write(1'b0, 32'h0000_2001);
        @(negedge clk);
        irq_hw = 7'b001_0000;
        exc_req = 1'b1; exc_kind = 3'd4; exc_vaddr = 32'hABCD_E123;
        exc_vector = 32'h8000_0000; cur_pc = 32'h0000_A000; in_delay_slot = 1'b0;
        @(negedge clk);
        exc_req = 1'b0;
        check("R11 no interrupt at request", {31'b0, redirect_o}, 32'd0);
        check("R11 fault code at capture", code_of(cause_o), 32'd3);
        @(negedge clk);
        check("R11 fault vector wins", redirect_pc_o, 32'h8000_0000);
        check("R11 fault code kept", code_of(cause_o), 32'd3);
        check("R6 entryhi store fault", entryhi_o, 32'hABCD_E000);
        @(negedge clk);
        check("R11 no interrupt after entry", {31'b0, redirect_o}, 32'd0);
        irq_hw = '0;
        csr_write(1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_break_syscall();
        t_cause_preserve();
        t_cop();
        t_tlb();
        t_overlap();
        t_irq();
        t_priority();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule